// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between an SDRAM command scheduler and the memory interface. It holds back each ACTIVATE, READ, WRITE, PRECHARGE or REFRESH command until the minimum clock spacing since the earlier command that constrains it has passed. A command that is allowed goes straight through in the same cycle. A command that is not allowed is stalled by keeping `in_ready` low. The scheduler keeps the command on its inputs until it is taken.

The spacings come from a 32-bit timing word that software writes into a shadow copy. The shadow copy is decoded and committed to the live timing set only on a 0-to-1 transition of a program input, so a partly written configuration never drives the checks. Each field has its own code-to-cycles mapping. A reserved code is clamped to the shortest legal spacing and raises a sticky error flag. The block also counts the CAS latency after every accepted READ and pulses a flag in the cycle the read data is due.

Top module: `sdrg_top`

## Requirements
- R1: After reset the live timings are the decode of 32'h2A733225: CAS latency 2, REFRESH spacing 11, ACTIVATE-to-PRECHARGE 8, PRECHARGE-to-ACTIVATE 3, ACTIVATE-to-column 3 and ACTIVATE-to-ACTIVATE 2 cycles. `cfg_err` and `rd_data_valid` are 0.
- R2: A write stores the word in a shadow copy only. The live timings change only when `cfg_prog` is sampled high at an edge after being sampled low at the previous edge. Commands accepted from the next cycle onward use the shadow value that was held before that edge. Holding `cfg_prog` high commits nothing further. Field positions: CAS latency [30:28], REFRESH spacing [27:24], ACTIVATE-to-PRECHARGE [23:20], PRECHARGE-to-ACTIVATE [18:16], ACTIVATE-to-column [14:12], ACTIVATE-to-ACTIVATE [10:8]. All other bits are ignored.
- R3: Decoding works as follows. The CAS latency code c (2..7) gives c cycles. Each 4-bit code c (1..15) gives c+1 cycles. Each 3-bit code c (1..7) gives c cycles.
- R4: Some codes are reserved: CAS latency 000 and 001, 4-bit code 0000, and 3-bit code 000. When one of them is committed it is clamped to 2 cycles (CAS latency and 4-bit fields) or 1 cycle (3-bit fields). `cfg_err` goes high and stays high until reset.
- R5: A READ or WRITE to a bank is not accepted sooner than ACTIVATE-to-column cycles after an ACTIVATE to that bank. A spacing of N means a later acceptance cycle u and earlier acceptance cycle t satisfy u-t >= N.
- R6: A PRECHARGE to a bank is not accepted sooner than ACTIVATE-to-PRECHARGE cycles after an ACTIVATE to that bank.
- R7: An ACTIVATE to a bank is not accepted sooner than PRECHARGE-to-ACTIVATE cycles after a PRECHARGE to that bank.
- R8: A REFRESH or ACTIVATE (any bank) is not accepted sooner than the REFRESH spacing after a REFRESH.
- R9: An ACTIVATE is not accepted sooner than ACTIVATE-to-ACTIVATE cycles after an ACTIVATE to any bank.
- R10: Command codes are 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH; others are never held back. `in_ready` equals `out_ready` AND timing met, `out_valid` equals `in_valid` AND timing met, and `out_op` and `out_bank` follow the inputs. A bank's timers never hold back commands to another bank.
- R11: `rd_data_valid` is high in cycle t+CL for every READ accepted in cycle t. Back-to-back READs give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the shadow timing word |
| cfg_wr_data | input | 32 | Timing word to store |
| cfg_prog | input | 1 | Program control; a 0-to-1 transition commits the shadow word |
| cfg_err | output | 1 | Sticky flag: a reserved code was committed |
| in_valid | input | 1 | Upstream command valid |
| in_ready | output | 1 | Command accepted this cycle when high with in_valid |
| in_op | input | 3 | Upstream command code |
| in_bank | input | BANK_W (2) | Upstream component bank index |
| out_valid | output | 1 | Downstream command valid |
| out_ready | input | 1 | Downstream can take a command |
| out_op | output | 3 | Downstream command code |
| out_bank | output | BANK_W (2) | Downstream bank index |
| rd_data_valid | output | 1 | Read data due this cycle |

## Verification
Every command result is due in its own cycle. A command issued as early as possible is accepted exactly N cycles after the command that constrains it, so the bench measures the spacing between acceptance cycles and compares it with the decoded value as an exact equality, not a bound. A read-valid pulse is due exactly CL cycles after the READ was accepted. The bench logs `rd_data_valid` once per cycle and checks both the due cycle and the cycle before it. A commit takes effect at the clock edge that samples the rising program input, so the bench checks timing only from the following cycle on.

// File: rtl/sdrg_pkg.sv
package sdrg_pkg;

    localparam int OP_W    = 3;
    localparam int CNT_W   = 5;
    localparam int LAT_MAX = 7;
    localparam logic [31:0] TIM_RESET = 32'h2A73_3225;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5
    } op_e;

    // raw codes as held in the shadow copy
    typedef struct packed {
        logic [2:0] cl;
        logic [3:0] rc;
        logic [3:0] ras;
        logic [2:0] rp;
        logic [2:0] rcd;
        logic [2:0] rrd;
    } code_s;

    // decoded cycle counts used by the gates
    typedef struct packed {
        logic [2:0]       cl;
        logic [CNT_W-1:0] rc;
        logic [CNT_W-1:0] ras;
        logic [2:0]       rp;
        logic [2:0]       rcd;
        logic [2:0]       rrd;
    } tim_s;

    function automatic code_s word_to_code(input logic [31:0] w);
        return {w[30:20], w[18:16], w[14:12], w[10:8]};
    endfunction

    function automatic logic [2:0] dec_lat(input logic [2:0] c);
        return (c < 3'd2) ? 3'd2 : c;
    endfunction

    function automatic logic [CNT_W-1:0] dec_long(input logic [3:0] c);
        return (c == 4'd0) ? CNT_W'(2) : CNT_W'(c) + CNT_W'(1);
    endfunction

    function automatic logic [2:0] dec_short(input logic [2:0] c);
        return (c == 3'd0) ? 3'd1 : c;
    endfunction

    function automatic tim_s decode(input code_s c);
        tim_s t;
        t.cl  = dec_lat(c.cl);
        t.rc  = dec_long(c.rc);
        t.ras = dec_long(c.ras);
        t.rp  = dec_short(c.rp);
        t.rcd = dec_short(c.rcd);
        t.rrd = dec_short(c.rrd);
        return t;
    endfunction

    function automatic logic has_reserved(input code_s c);
        return (c.cl < 3'd2) || (c.rc == 4'd0) || (c.ras == 4'd0) ||
               (c.rp == 3'd0) || (c.rcd == 3'd0) || (c.rrd == 3'd0);
    endfunction

endpackage

// File: rtl/sdrg_cfg.sv
module sdrg_cfg
    import sdrg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        prog,
    output tim_s        tim,
    output logic        err
);

    localparam code_s RST_CODE = word_to_code(TIM_RESET);
    localparam tim_s  RST_TIM  = decode(RST_CODE);

    code_s shadow_q;
    tim_s  tim_q;
    logic  prog_q;
    logic  err_q;
    logic  commit;
    logic  unused_bits;

    assign unused_bits = ^{wr_data[31], wr_data[19], wr_data[15], wr_data[11], wr_data[7:0]};
    assign commit      = prog && !prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RST_CODE;
            tim_q    <= RST_TIM;
            prog_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            prog_q <= prog;
            if (wr_en)
                shadow_q <= word_to_code(wr_data);
            if (commit) begin
                tim_q <= decode(shadow_q);
                err_q <= err_q | has_reserved(shadow_q);
            end
        end
    end

    assign tim = tim_q;
    assign err = err_q;

    // R2: live timings move only on a program rising edge
    a_r2_commit_on_edge: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(tim_q));

    // R4: error flag never clears outside reset
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/sdrg_gap_ctr.sv
module sdrg_gap_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] gap,
    output logic             ok
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= gap - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign ok = (cnt_q == '0);

    // R5 (and R6, R7, R8, R9 through the same counter): a gap above one blocks the next cycle
    a_r5_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (load && gap > CNT_W'(1)) |=> !ok);

    // R5: once open, the window stays open until a new load
    a_r5_gap_release: assert property (@(posedge clk) disable iff (rst)
        (ok && !load) |=> ok);

endmodule

// File: rtl/sdrg_rd_pipe.sv
module sdrg_rd_pipe #(
    parameter int DEPTH = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_hit,
    input  logic [2:0] lat,
    output logic       rd_valid
);

    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] sr_d;

    always_comb begin
        sr_d = sr_q >> 1;
        if (rd_hit && lat != 3'd0 && int'(lat) <= DEPTH)
            sr_d[int'(lat) - 1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else
            sr_q <= sr_d;
    end

    assign rd_valid = sr_q[0];

    // R11: with a latency of at least two, a read never flags data in the very next cycle by itself
    a_r11_no_early: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && lat >= 3'd2 && sr_q[1] == 1'b0) |=> !rd_valid);

endmodule

// File: rtl/sdrg_top.sv
module sdrg_top
    import sdrg_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    input  logic              cfg_prog,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [BANK_W-1:0] in_bank,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OP_W-1:0]   out_op,
    output logic [BANK_W-1:0] out_bank,
    output logic              rd_data_valid
);

    localparam int NUM_BANKS = 1 << BANK_W;

    tim_s                 tim;
    op_e                  op;
    logic                 go;
    logic                 fire;
    logic                 rc_ok;
    logic                 rrd_ok;
    logic [NUM_BANKS-1:0] act_ok;
    logic [NUM_BANKS-1:0] pre_ok;
    logic [NUM_BANKS-1:0] col_ok;

    assign op = op_e'(in_op);

    sdrg_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .prog    (cfg_prog),
        .tim     (tim),
        .err     (cfg_err)
    );

    always_comb begin
        case (op)
            OP_ACT:        go = act_ok[in_bank] && rc_ok && rrd_ok;
            OP_RD, OP_WR:  go = col_ok[in_bank];
            OP_PRE:        go = pre_ok[in_bank];
            OP_REF:        go = rc_ok;
            default:       go = 1'b1;
        endcase
    end

    assign in_ready  = out_ready && go;
    assign out_valid = in_valid && go;
    assign out_op    = in_op;
    assign out_bank  = in_bank;
    assign fire      = in_valid && in_ready;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = fire && (in_bank == BANK_W'(b));

        sdrg_gap_ctr #(.CNT_W(CNT_W)) u_ras (
            .clk  (clk),
            .rst  (rst),
            .load (hit && op == OP_ACT),
            .gap  (tim.ras),
            .ok   (pre_ok[b])
        );

        sdrg_gap_ctr #(.CNT_W(CNT_W)) u_rcd (
            .clk  (clk),
            .rst  (rst),
            .load (hit && op == OP_ACT),
            .gap  (CNT_W'(tim.rcd)),
            .ok   (col_ok[b])
        );

        sdrg_gap_ctr #(.CNT_W(CNT_W)) u_rp (
            .clk  (clk),
            .rst  (rst),
            .load (hit && op == OP_PRE),
            .gap  (CNT_W'(tim.rp)),
            .ok   (act_ok[b])
        );
    end

    sdrg_gap_ctr #(.CNT_W(CNT_W)) u_rc (
        .clk  (clk),
        .rst  (rst),
        .load (fire && op == OP_REF),
        .gap  (tim.rc),
        .ok   (rc_ok)
    );

    sdrg_gap_ctr #(.CNT_W(CNT_W)) u_rrd (
        .clk  (clk),
        .rst  (rst),
        .load (fire && op == OP_ACT),
        .gap  (CNT_W'(tim.rrd)),
        .ok   (rrd_ok)
    );

    sdrg_rd_pipe #(.DEPTH(LAT_MAX)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_hit   (fire && op == OP_RD),
        .lat      (tim.cl),
        .rd_valid (rd_data_valid)
    );

    // R10: nothing is taken from upstream unless downstream takes it
    a_r10_ready_needs_sink: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_ready);

    // R10: an accepted command is always offered downstream
    a_r10_accept_forwards: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (out_valid && out_ready));

endmodule

// File: tb/sdrg_top_tb.sv
module sdrg_top_tb_top;

    localparam logic [2:0] C_ACT = 3'd1;
    localparam logic [2:0] C_RD  = 3'd2;
    localparam logic [2:0] C_WR  = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4;
    localparam logic [2:0] C_REF = 3'd5;
    localparam logic [31:0] W_NEW = 32'h5352_4300; // CL5 rc4 ras6 rp2 rcd4 rrd3

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_prog = 1'b0;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = C_REF;
    logic [1:0]  in_bank = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_op;
    logic [1:0]  out_bank;
    logic        rd_data_valid;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit rdv_log [0:4095];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (cyc < 4096) rdv_log[cyc] = rd_data_valid;

    sdrg_top dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_data   (cfg_wr_data),
        .cfg_prog      (cfg_prog),
        .cfg_err       (cfg_err),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_op         (in_op),
        .in_bank       (in_bank),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_op        (out_op),
        .out_bank      (out_bank),
        .rd_data_valid (rd_data_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called just after a negedge; returns the cycle in which the command was taken
    task automatic issue(input logic [2:0] op, input int bank, output int t);
        int w = 0;
        in_valid = 1'b1;
        in_op    = op;
        in_bank  = 2'(bank);
        #1;
        while (!in_ready && w < 200) begin
            @(negedge clk); #1;
            w++;
        end
        if (!in_ready) check("R10 command never accepted", 0, 1);
        t = cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] w);
        cfg_wr_en = 1'b1;
        cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse_prog();
        cfg_prog = 1'b1;
        @(negedge clk);
        cfg_prog = 1'b0;
        @(negedge clk);
    endtask

    task automatic rdv_due(input string req, input int t, input int cl);
        while (cyc <= t + cl + 1) @(negedge clk);
        check(req, int'(rdv_log[t + cl]), 1);
        check(req, int'(rdv_log[t + cl - 1]), 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check("R1 cfg_err after reset", int'(cfg_err), 0);
        check("R1 rd_data_valid after reset", int'(rd_data_valid), 0);
        check("R10 idle REF ready", int'(in_ready), 1);
        check("R10 out_valid idle", int'(out_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_default_bank();
        int ta, tr, tp, ta2;
        idle(5);
        issue(C_ACT, 0, ta);
        issue(C_RD, 0, tr);
        check("R5 default ACT->RD", tr - ta, 3);
        issue(C_PRE, 0, tp);
        check("R6 default ACT->PRE", tp - ta, 8);
        issue(C_ACT, 0, ta2);
        check("R7 default PRE->ACT", ta2 - tp, 3);
        rdv_due("R11 default CL2 read valid", tr, 2);
    endtask

    task automatic t_cross_bank();
        int ta, tb, tc, td;
        idle(20);
        issue(C_ACT, 1, ta);
        issue(C_ACT, 2, tb);
        check("R9 ACT->ACT other bank", tb - ta, 2);
        issue(C_WR, 1, tc);
        check("R10 bank1 WR not held by bank2", tc - tb, 1);
        issue(C_RD, 2, td);
        check("R5 bank2 ACT->RD", td - tb, 3);
    endtask

    task automatic t_refresh();
        int t1, t2, t3;
        idle(20);
        issue(C_REF, 0, t1);
        issue(C_REF, 0, t2);
        check("R8 REF->REF default", t2 - t1, 11);
        issue(C_ACT, 3, t3);
        check("R8 REF->ACT default", t3 - t2, 11);
    endtask

    task automatic t_stall();
        int ta, tr;
        idle(20);
        out_ready = 1'b0;
        in_valid = 1'b1; in_op = C_RD; in_bank = 2'd1;
        #1;
        check("R10 in_ready low with sink busy", int'(in_ready), 0);
        check("R10 out_valid offered", int'(out_valid), 1);
        check("R10 out_op forwarded", int'(out_op), int'(C_RD));
        check("R10 out_bank forwarded", int'(out_bank), 1);
        @(negedge clk);
        out_ready = 1'b1;
        idle(2);
        issue(C_ACT, 1, ta);
        in_valid = 1'b1; in_op = C_RD; in_bank = 2'd1;
        #1;
        check("R5 RD held right after ACT: in_ready", int'(in_ready), 0);
        check("R10 out_valid low while held", int'(out_valid), 0);
        issue(C_RD, 1, tr);
        check("R5 held RD accepted on time", tr - ta, 3);
    endtask

    task automatic t_commit();
        int ta, tr, tr2, tp, ta2, f1, f2, a1, a2;
        idle(20);
        write_word(W_NEW);
        idle(3);
        issue(C_ACT, 2, ta);
        issue(C_RD, 2, tr);
        check("R2 shadow write has no effect before program", tr - ta, 3);
        idle(20);
        pulse_prog();
        idle(20);
        issue(C_ACT, 3, ta);
        issue(C_RD, 3, tr);
        check("R3 ACT->RD code 100", tr - ta, 4);
        issue(C_RD, 3, tr2);
        check("R5 RD->RD same bank", tr2 - tr, 1);
        issue(C_PRE, 3, tp);
        check("R6 ACT->PRE code 0101", tp - ta, 6);
        issue(C_ACT, 3, ta2);
        check("R7 PRE->ACT code 010", ta2 - tp, 2);
        idle(10);
        issue(C_REF, 0, f1);
        issue(C_REF, 0, f2);
        check("R8 REF->REF code 0011", f2 - f1, 4);
        issue(C_ACT, 0, a1);
        check("R8 REF->ACT code 0011", a1 - f2, 4);
        issue(C_ACT, 1, a2);
        check("R9 ACT->ACT code 011", a2 - a1, 3);
        rdv_due("R11 CL5 first read", tr, 5);
        check("R11 CL5 second read", int'(rdv_log[tr2 + 5]), 1);
        check("R11 CL5 no pulse after pair", int'(rdv_log[tr2 + 6]), 0);
        check("R4 cfg_err legal codes", int'(cfg_err), 0);
    endtask

    task automatic t_reserved();
        int ta, tr, tp, ta2, f1, f2;
        idle(20);
        write_word(32'h0000_0000);
        pulse_prog();
        #1;
        check("R4 cfg_err set by reserved codes", int'(cfg_err), 1);
        idle(20);
        issue(C_ACT, 0, ta);
        issue(C_RD, 0, tr);
        check("R4 clamped ACT->RD", tr - ta, 1);
        issue(C_PRE, 0, tp);
        check("R4 clamped ACT->PRE", tp - ta, 2);
        issue(C_ACT, 0, ta2);
        check("R4 clamped PRE->ACT", ta2 - tp, 1);
        issue(C_REF, 0, f1);
        issue(C_REF, 0, f2);
        check("R4 clamped REF->REF", f2 - f1, 2);
        rdv_due("R4 clamped CL read valid", tr, 2);
    endtask

    task automatic t_prog_held();
        int ta, tr;
        idle(10);
        cfg_prog = 1'b1;
        @(negedge clk);
        write_word(W_NEW);
        idle(3);
        issue(C_ACT, 1, ta);
        issue(C_RD, 1, tr);
        check("R2 held program commits nothing", tr - ta, 1);
        cfg_prog = 1'b0;
        idle(2);
        cfg_prog = 1'b1;
        idle(20);
        issue(C_ACT, 2, ta);
        issue(C_RD, 2, tr);
        check("R2 fresh rising edge commits", tr - ta, 4);
        check("R4 cfg_err stays set", int'(cfg_err), 1);
        cfg_prog = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_bank();
        t_cross_bank();
        t_refresh();
        t_stall();
        t_commit();
        t_reserved();
        t_prog_held();
        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule